// File: doc/BRIEF.md
# Dual-Clock Buffer with Programmable Threshold Flags

This block is a 64-entry, 18-bit first-in first-out buffer. It sits between two independent clock domains. A producer pushes a word on a rising edge of the load clock while `loadEn` is high. A consumer pops a word on a rising edge of the unload clock while `unloadEn` is high. The two pointers cross between the domains as Gray codes through two-flop synchronizers. As a result, every flag errs on the safe side: a domain may briefly see the buffer fuller (writer) or emptier (reader) than it really is.

Four status outputs are provided:
- An active-low full flag and an active-low empty flag.
- A half-full flag.
- A single combined threshold flag. It is high near either end of the buffer.

The lower threshold X and the upper offset Y are programmed in-band. After reset, while `progEnN` is low, the first one or two accepted load edges take the offset from the low six data bits. These edges store no word. If the programming is skipped, both offsets default to 8.

Top module: `strobed_fifo`

## Requirements
- R1: Words leave on `dataOut` in the order they were accepted, with no loss or duplication, for up to 64 stored words.
- R2: A load edge while 64 words are held (as seen by the write side) stores nothing, and the held contents are unchanged.
- R3: An unload edge while the read side sees no words has no effect; `dataOut` keeps its last value.
- R4: `fullN` is 0 exactly when the write-side occupancy is 64, and 1 otherwise.
- R5: `emptyN` is 0 exactly when the read-side occupancy is 0, and 1 otherwise.
- R6: `halfFull` is 1 when the write-side occupancy is 32 or more, and 0 at 31 or fewer.
- R7: After reset with `progEnN` low, the first load edge copies `dataIn[5:0]` into X and stores no data word.
- R8: A second load edge with `progEnN` still low copies `dataIn[5:0]` into Y and stores no data word. If only one programming edge occurs, Y equals X.
- R9: If `progEnN` is high at the first load edge after reset, X and Y both stay 8, and that edge stores a data word.
- R10: `almostFlag` is 1 when the write-side occupancy is at most X or at least 64 − Y. It is 0 otherwise.
- R11: The active-low asynchronous reset empties the buffer, sets `dataOut` to 0, and re-arms offset programming. Right after reset, `fullN` = 1, `emptyN` = 0, `halfFull` = 0 and `almostFlag` = 1.
- R12: Each pointer crosses domains as a Gray code that changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Load clock |
| rdClk | input | 1 | Unload clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Load request, sampled on `wrClk` |
| progEnN | input | 1 | Offset programming enable, active low |
| dataIn | input | 18 | Write data; bits 5:0 also carry offsets |
| unloadEn | input | 1 | Unload request, sampled on `rdClk` |
| dataOut | output | 18 | Registered read data |
| fullN | output | 1 | Low when full |
| emptyN | output | 1 | Low when empty |
| halfFull | output | 1 | High at 32 or more words |
| almostFlag | output | 1 | Combined near-empty / near-full flag |

## Verification
The assertions assume that `loadEn`, `progEnN` and `dataIn` change only away from rising `wrClk` edges. They assume the same of `unloadEn` with respect to `rdClk`. They also assume that reset is released while no request is active. The bench meets these conditions by driving every input on the falling edge of the clock that samples it. It applies and releases reset with both request lines held low. Before it compares any cross-domain flag against its reference queue, it waits several edges of both clocks so the synchronizers settle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 18;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int PTR_W       = ADDR_W + 1;
  localparam int HALF        = DEPTH / 2;
  localparam int DEFAULT_OFS = 8;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
  } wrStb_t;

  typedef struct packed {
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } rdStb_t;

  typedef enum logic [1:0] {
    PG_X    = 2'd0,
    PG_Y    = 2'd1,
    PG_DONE = 2'd2
  } progState_t;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/sfifo_sync2.sv
module sfifo_sync2 #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage[0] <= '0;
    end else begin
      stage[0] <= d;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[s] <= '0;
      end else begin
        stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  wrStb_t        wrStb,
  input  rdStb_t        rdStb,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (wrStb.wrEn) begin
      mem[wrStb.wrAddr] <= dataIn;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (rdStb.rdEn) begin
      dataOut <= mem[rdStb.rdAddr];
    end
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              progEnN,
  input  logic [ADDR_W-1:0] ofsIn,
  input  logic              unloadEn,
  output wrStb_t            wrStb,
  output rdStb_t            rdStb,
  output logic              fullN,
  output logic              emptyN,
  output logic              halfFull,
  output logic              almostFlag,
  output logic [PTR_W-1:0]  wrGray,
  output logic [PTR_W-1:0]  rdGray,
  output logic [PTR_W-1:0]  occW
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(HALF);
  localparam logic [ADDR_W-1:0] DEF_P  = ADDR_W'(DEFAULT_OFS);

  // ---------------- write domain ----------------
  progState_t        progState;
  logic [ADDR_W-1:0] ofsX, ofsY;
  logic [PTR_W-1:0]  wrBin, rdGraySync, rdBinW, upperMark;
  logic              isFull, progCycle, wrAccept;

  sfifo_sync2 #(.W(PTR_W), .STAGES(SYNC_STAGES)) uRdToWr (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );

  assign rdBinW    = gray2bin(rdGraySync);
  assign occW      = wrBin - rdBinW;
  assign isFull    = (occW == DEPTH_P);
  assign progCycle = loadEn && !progEnN && (progState != PG_DONE);
  assign wrAccept  = loadEn && !progCycle && !isFull;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      progState <= PG_X;
      ofsX      <= DEF_P;
      ofsY      <= DEF_P;
    end else if (progCycle) begin
      if (progState == PG_X) begin
        ofsX      <= ofsIn;
        ofsY      <= ofsIn;
        progState <= PG_Y;
      end else begin
        ofsY      <= ofsIn;
        progState <= PG_DONE;
      end
    end else if (loadEn) begin
      progState <= PG_DONE;
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrAccept) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= bin2gray(wrBin + 1'b1);
    end
  end

  assign upperMark  = DEPTH_P - {1'b0, ofsY};
  assign fullN      = !isFull;
  assign halfFull   = (occW >= HALF_P);
  assign almostFlag = (occW <= {1'b0, ofsX}) || (occW >= upperMark);
  assign wrStb      = '{wrEn: wrAccept, wrAddr: wrBin[ADDR_W-1:0]};

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rdBin, wrGraySync, occR;
  logic             isEmpty, rdAccept;

  sfifo_sync2 #(.W(PTR_W), .STAGES(SYNC_STAGES)) uWrToRd (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  assign occR     = gray2bin(wrGraySync) - rdBin;
  assign isEmpty  = (occR == '0);
  assign rdAccept = unloadEn && !isEmpty;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdAccept) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= bin2gray(rdBin + 1'b1);
    end
  end

  assign emptyN = !isEmpty;
  assign rdStb  = '{rdEn: rdAccept, rdAddr: rdBin[ADDR_W-1:0]};
endmodule

// File: rtl/strobed_fifo.sv
module strobed_fifo
  import sfifo_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          loadEn,
  input  logic          progEnN,
  input  logic [DW-1:0] dataIn,
  input  logic          unloadEn,
  output logic [DW-1:0] dataOut,
  output logic          fullN,
  output logic          emptyN,
  output logic          halfFull,
  output logic          almostFlag
);
  wrStb_t           wrStb;
  rdStb_t           rdStb;
  logic [PTR_W-1:0] wrGray, rdGray, occW;

  sfifo_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .loadEn(loadEn), .progEnN(progEnN), .ofsIn(dataIn[ADDR_W-1:0]),
    .unloadEn(unloadEn), .wrStb(wrStb), .rdStb(rdStb),
    .fullN(fullN), .emptyN(emptyN), .halfFull(halfFull),
    .almostFlag(almostFlag), .wrGray(wrGray), .rdGray(rdGray), .occW(occW)
  );

  sfifo_store #(.DW(DW)) uStore (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrStb(wrStb), .rdStb(rdStb), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker
  import sfifo_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             loadEn,
  input logic [DW-1:0]    dataOut,
  input logic             fullN,
  input logic             emptyN,
  input logic             halfFull,
  input logic [PTR_W-1:0] wrGray,
  input logic [PTR_W-1:0] rdGray,
  input logic [PTR_W-1:0] occW
);
  // R2: a load while full leaves the write pointer where it was
  p_full_blocks_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fullN && loadEn) |=> $stable(wrGray));

  // R3: while empty, the output register holds
  p_empty_holds_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(dataOut));

  // R4: the write-side occupancy never exceeds the depth
  p_no_overflow_r4: assert property (@(posedge wrClk) disable iff (!rstN)
    occW <= PTR_W'(DEPTH));

  // R6: full implies half full
  p_full_half_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> halfFull);

  // R12: Gray pointers move by at most one bit per edge
  p_wr_gray_step_r12: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  p_rd_gray_step_r12: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
endmodule

bind strobed_fifo sfifo_checker #(.DW(DW)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .loadEn(loadEn),
  .dataOut(dataOut), .fullN(fullN), .emptyN(emptyN), .halfFull(halfFull),
  .wrGray(wrGray), .rdGray(rdGray), .occW(occW)
);

// File: tb/strobed_fifo_test.sv
module strobed_fifo_test;
  logic        wrClk = 0, rdClk = 0, rstN = 0;
  logic        loadEn = 0, unloadEn = 0, progEnN = 1;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic        fullN, emptyN, halfFull, almostFlag;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [17:0] q[$];
  logic [17:0] nextVal = 18'h00100;

  strobed_fifo uut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .loadEn(loadEn),
    .progEnN(progEnN), .dataIn(dataIn), .unloadEn(unloadEn),
    .dataOut(dataOut), .fullN(fullN), .emptyN(emptyN),
    .halfFull(halfFull), .almostFlag(almostFlag)
  );

  always #5 wrClk = ~wrClk;   // 100 MHz
  always #7 rdClk = ~rdClk;   // unrelated read clock

  // occupancy, fullN, emptyN, halfFull, almostFlag for X=5, Y=10
  localparam logic [10:0] FLAG_TAB [10] = '{
    {7'd0,  4'b1001}, {7'd1,  4'b1101}, {7'd5,  4'b1101}, {7'd6,  4'b1100},
    {7'd31, 4'b1100}, {7'd32, 4'b1110}, {7'd53, 4'b1110}, {7'd54, 4'b1111},
    {7'd63, 4'b1111}, {7'd64, 4'b0111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge wrClk);
    repeat (5) @(negedge rdClk);
  endtask

  task automatic pushRaw(input logic [17:0] v);
    @(negedge wrClk);
    loadEn = 1; dataIn = v;
    @(negedge wrClk);
    loadEn = 0;
  endtask

  task automatic pushData();
    pushRaw(nextVal);
    q.push_back(nextVal);
    nextVal++;
  endtask

  task automatic popWord();
    @(negedge rdClk);
    unloadEn = 1;
    @(negedge rdClk);
    unloadEn = 0;
  endtask

  task automatic fillTo(input int n);
    while (q.size() < n) pushData();
    settle();
  endtask

  task automatic drainCheck(input string req);
    while (q.size() > 0) begin
      popWord();
      check(req, dataOut, q.pop_front());
    end
    settle();
  endtask

  task automatic doReset(input logic pen);
    @(negedge wrClk);
    loadEn = 0; unloadEn = 0; progEnN = pen;
    #3 rstN = 0;
    #20 rstN = 1;
    q.delete();
    settle();
  endtask

  task automatic checkFlags(input string req, input logic [3:0] exp);
    check(req, {fullN, emptyN, halfFull, almostFlag}, {28'd0, exp});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #23 rstN = 1;
    settle();
    // R11: state right after reset
    checkFlags("R11 reset flags", 4'b1001);
    check("R11 reset dataOut", dataOut, 18'h0);

    // R7/R8: two programming edges, X=5 Y=10
    progEnN = 0;
    pushRaw(18'h3FC05);
    pushRaw(18'h3FC0A);
    progEnN = 1;
    for (int i = 0; i < 10; i++) begin
      fillTo(int'(FLAG_TAB[i][10:4]));
      // R4 R5 R6 R10 (entry 0 also shows R7: programming stored nothing)
      checkFlags($sformatf("R4/R5/R6/R10 occ=%0d", FLAG_TAB[i][10:4]), FLAG_TAB[i][3:0]);
    end

    // R2: load while full is dropped
    pushRaw(18'h2BAD5);
    settle();
    check("R2 still full", fullN, 1'b0);
    drainCheck("R1/R2 order after full");
    check("R5 empty after drain", emptyN, 1'b0);

    // R3: unload while empty has no effect
    begin
      logic [17:0] last;
      last = dataOut;
      popWord(); popWord();
      settle();
      check("R3 dataOut held", dataOut, last);
      check("R3 still empty", emptyN, 1'b0);
    end

    // R11: reset with contents empties and re-arms programming
    repeat (10) pushData();
    settle();
    check("R11 pre-reset not empty", emptyN, 1'b1);
    doReset(1'b0);
    checkFlags("R11 flags after reset", 4'b1001);
    check("R11 dataOut cleared", dataOut, 18'h0);

    // R8: a single programming edge gives Y = X = 3
    pushRaw(18'h00003);
    progEnN = 1;
    fillTo(3);  check("R8 alm at X", almostFlag, 1'b1);
    fillTo(4);  check("R8 alm above X", almostFlag, 1'b0);
    fillTo(60); check("R8 alm below 64-Y", almostFlag, 1'b0);
    fillTo(61); check("R8 alm at 64-Y", almostFlag, 1'b1);
    popWord();
    check("R7 first read is first data word", dataOut, q.pop_front());
    drainCheck("R1 order one-edge program");

    // R9: program enable high, default offsets and first edge is data
    doReset(1'b1);
    fillTo(1);  check("R9 first edge stored", emptyN, 1'b1);
    fillTo(8);  check("R9 alm at default X", almostFlag, 1'b1);
    fillTo(9);  check("R9 alm above default X", almostFlag, 1'b0);
    fillTo(55); check("R9 alm below 56", almostFlag, 1'b0);
    fillTo(56); check("R9 alm at 56", almostFlag, 1'b1);
    drainCheck("R1/R9 order defaults");

    // R1: concurrent producer and consumer
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          pushData();
          if (i % 3 == 0) @(negedge wrClk);
        end
      end
      begin
        int got = 0;
        while (got < 40) begin
          @(negedge rdClk);
          if (emptyN) begin
            unloadEn = 1;
            @(negedge rdClk);
            unloadEn = 0;
            check("R1 concurrent order", dataOut, q.pop_front());
            got++;
          end
        end
      end
    join
    settle();
    checkFlags("R5/R10 empty after stream", 4'b1001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule